// File: doc/BRIEF.md
# Per-Channel Scaled Monitor Result Stage

This block sits after a shared converter in a four-channel measurement front end. Each conversion arrives as a raw unsigned word together with the index of the channel it belongs to. The block divides the word by a power of two chosen for that channel, using a logical right shift of zero to seven places. It then stores the scaled value in that channel's result register and compares it with the channel's own high and low limits.

The same scaled value drives both the stored result and the two limit comparisons. Limits and stored readings therefore always carry the same bit weight. A channel whose signal uses only a fraction of the converter span can be calibrated to that fraction and shifted back down, so the published weighting stays fixed. No conversion kind bypasses the shift, and calibration conversions pass through the same path.

Results, flags and a completion strobe all update on the clock edge that accepts the conversion. Each flag stays readable until the next conversion of its own channel.

Top module: `adc_scale_monitor`

## Requirements
- R1: While reset is held, and after it is released until the first conversion, every result register reads 0 and every high flag, low flag and the done strobe read 0.
- R2: The shift count of channel i is 3 bits taken from configuration byte i/2 (byte k at shift_cfg bits 8k+7..8k). An even channel uses bits 2..0 of its byte and an odd channel uses bits 6..4.
- R3: The stored value is raw shifted right logically by the channel's count (0 to 7), with zeros entering at the top. A count of 0 passes raw unchanged, and a count of 7 applied to 16'hFFFF gives 16'h01FF.
- R4: One clock edge after conv_valid is sampled high, the result register of channel chan holds the scaled value. The other channels' results are unchanged.
- R5: On the same edge, the high flag of channel chan is set exactly when the scaled value is greater than that channel's high limit (unsigned). A value equal to the limit clears it.
- R6: On the same edge, the low flag of channel chan is set exactly when the scaled value is less than that channel's low limit (unsigned). A value equal to the limit clears it.
- R7: Flags and results of a channel change only on a conversion of that channel. With conv_valid low, all flags and results hold.
- R8: done is high for exactly the cycle after each cycle in which conv_valid was sampled high, and low otherwise. Back-to-back conversions give consecutive done cycles.
- R9: Bits 3 and 7 of every configuration byte have no effect on any result or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | A conversion is presented this cycle |
| chan | input | 2 | Channel index of the conversion |
| raw | input | 16 | Unsigned converter word |
| shift_cfg | input | 16 | Two configuration bytes holding the four 3-bit shift counts |
| thr_hi | input | 64 | High limits; channel i at bits 16i+15..16i |
| thr_lo | input | 64 | Low limits; channel i at bits 16i+15..16i |
| result | output | 64 | Scaled result registers; channel i at bits 16i+15..16i |
| alarm_hi | output | 4 | High flag per channel |
| alarm_lo | output | 4 | Low flag per channel |
| done | output | 1 | One-cycle strobe following each accepted conversion |

## Verification
Every result register, flag and the done strobe is due on the first rising edge after the cycle in which conv_valid is high. There is no further pipeline stage. The bench drives each conversion on a falling edge and samples all outputs on the following falling edge, half a cycle after they settle. It then samples done again one cycle later to confirm the strobe has dropped. Back-to-back conversions are checked the same way on each successive falling edge. Idle stretches are checked for unchanged results and flags.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int SHIFT_W       = 3;
    localparam int CFG_BYTE_W    = 8;
    localparam int CH_PER_BYTE   = 2;
    localparam int FIELD_PITCH   = CFG_BYTE_W / CH_PER_BYTE;

    typedef logic [SHIFT_W-1:0] shamt_t;

endpackage

// File: rtl/scl_cfg_unpack.sv
module scl_cfg_unpack
    import scl_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CFG_W = (NUM_CH / CH_PER_BYTE) * CFG_BYTE_W
) (
    input  logic [CFG_W-1:0]           cfg_flat,
    output shamt_t [NUM_CH-1:0]        amt
);

    localparam int PAD_W = FIELD_PITCH - SHIFT_W;

    logic [NUM_CH*PAD_W-1:0] spare_bits;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_field
        localparam int BASE = (i / CH_PER_BYTE) * CFG_BYTE_W
                            + (i % CH_PER_BYTE) * FIELD_PITCH;
        assign amt[i] = cfg_flat[BASE +: SHIFT_W];
        assign spare_bits[i*PAD_W +: PAD_W] = cfg_flat[BASE + SHIFT_W +: PAD_W];
    end

    logic unused_spare;
    assign unused_spare = ^spare_bits;

endmodule

// File: rtl/scl_rshift.sv
module scl_rshift
    import scl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  shamt_t            amt,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stage [SHIFT_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k] ? (stage[k] >> STEP) : stage[k];
    end

    assign dout = stage[SHIFT_W];

endmodule

// File: rtl/scl_thresh_cmp.sv
module scl_thresh_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [DATA_W-1:0] lim_lo,
    output logic              over,
    output logic              under
);

    always_comb begin
        over  = (value > lim_hi);
        under = (value < lim_lo);
    end

endmodule

// File: rtl/adc_scale_monitor.sv
module adc_scale_monitor
    import scl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CFG_W = (NUM_CH / CH_PER_BYTE) * CFG_BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     conv_valid,
    input  logic [CH_W-1:0]          chan,
    input  logic [DATA_W-1:0]        raw,
    input  logic [CFG_W-1:0]         shift_cfg,
    input  logic [NUM_CH*DATA_W-1:0] thr_hi,
    input  logic [NUM_CH*DATA_W-1:0] thr_lo,
    output logic [NUM_CH*DATA_W-1:0] result,
    output logic [NUM_CH-1:0]        alarm_hi,
    output logic [NUM_CH-1:0]        alarm_lo,
    output logic                     done
);

    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] res;
        logic [NUM_CH-1:0]             hi;
        logic [NUM_CH-1:0]             lo;
        logic                          done;
    } state_t;

    state_t state_d, state_q;

    shamt_t [NUM_CH-1:0]           amt_all;
    shamt_t                        amt_sel;
    logic [NUM_CH-1:0][DATA_W-1:0] lim_hi_a, lim_lo_a;
    logic [DATA_W-1:0]             lim_hi_sel, lim_lo_sel;
    logic [DATA_W-1:0]             scaled;
    logic                          over, under;

    assign lim_hi_a = thr_hi;
    assign lim_lo_a = thr_lo;

    scl_cfg_unpack #(.NUM_CH(NUM_CH)) u_unpack (
        .cfg_flat (shift_cfg),
        .amt      (amt_all)
    );

    assign amt_sel    = amt_all[chan];
    assign lim_hi_sel = lim_hi_a[chan];
    assign lim_lo_sel = lim_lo_a[chan];

    scl_rshift #(.DATA_W(DATA_W)) u_shift (
        .din  (raw),
        .amt  (amt_sel),
        .dout (scaled)
    );

    scl_thresh_cmp #(.DATA_W(DATA_W)) u_cmp (
        .value  (scaled),
        .lim_hi (lim_hi_sel),
        .lim_lo (lim_lo_sel),
        .over   (over),
        .under  (under)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = conv_valid;
        if (conv_valid) begin
            state_d.res[chan] = scaled;
            state_d.hi[chan]  = over;
            state_d.lo[chan]  = under;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result   = state_q.res;
    assign alarm_hi = state_q.hi;
    assign alarm_lo = state_q.lo;
    assign done     = state_q.done;

    AST_DONE_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> done); // R8
    AST_DONE_ONLY_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid |=> !done); // R8
    AST_IDLE_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid |=> $stable(result)); // R7
    AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid |=> ($stable(alarm_hi) && $stable(alarm_lo))); // R7
    AST_SCALE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> (state_q.res[$past(chan)] <= $past(raw))); // R3
    AST_ZERO_SHIFT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && amt_sel == '0) |=> (state_q.res[$past(chan)] == $past(raw))); // R3
    AST_HIGH_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> (state_q.hi[$past(chan)] ==
                        (state_q.res[$past(chan)] > $past(lim_hi_sel)))); // R5
    AST_LOW_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> (state_q.lo[$past(chan)] ==
                        (state_q.res[$past(chan)] < $past(lim_lo_sel)))); // R6

endmodule

// File: tb/sim_adc_scale_monitor.sv
module sim_adc_scale_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [1:0]  chan = '0;
    logic [15:0] raw = '0;
    logic [15:0] shift_cfg = '0;
    logic [63:0] thr_hi = '1;
    logic [63:0] thr_lo = '0;
    logic [63:0] result;
    logic [3:0]  alarm_hi, alarm_lo;
    logic        done;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] exp_res [NCH];
    logic        exp_hi  [NCH];
    logic        exp_lo  [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scale_monitor u0 (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .chan(chan),
        .raw(raw), .shift_cfg(shift_cfg), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .result(result), .alarm_hi(alarm_hi), .alarm_lo(alarm_lo), .done(done)
    );

    function automatic logic [2:0] f_amt(logic [15:0] cfg, int ch);
        logic [7:0] b;
        b = cfg[8*(ch/2) +: 8];
        return (ch % 2 == 1) ? b[6:4] : b[2:0];
    endfunction

    function automatic logic [15:0] f_scale(logic [15:0] r, logic [2:0] a);
        return r >> a;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < NCH; i++) begin
            chk({tag, " R4 result"}, {16'h0, result[16*i +: 16]}, {16'h0, exp_res[i]});
            chk({tag, " R5 high flag"}, {31'h0, alarm_hi[i]}, {31'h0, exp_hi[i]});
            chk({tag, " R6 low flag"},  {31'h0, alarm_lo[i]}, {31'h0, exp_lo[i]});
        end
    endtask

    task automatic model_conv(int ch, logic [15:0] r);
        logic [15:0] s;
        s = f_scale(r, f_amt(shift_cfg, ch));
        exp_res[ch] = s;
        exp_hi[ch]  = s > thr_hi[16*ch +: 16];
        exp_lo[ch]  = s < thr_lo[16*ch +: 16];
    endtask

    // Drive on a falling edge; outputs are due at the next rising edge.
    task automatic conv(int ch, logic [15:0] r, string tag);
        chan = ch[1:0]; raw = r; conv_valid = 1'b1;
        @(negedge clk);
        conv_valid = 1'b0;
        model_conv(ch, r);
        chk({tag, " R8 done after conv"}, {31'h0, done}, 32'h1);
        check_all(tag);
        @(negedge clk);
        chk({tag, " R8 done drops"}, {31'h0, done}, 32'h0);
        check_all({tag, " R7 hold"});
    endtask

    task automatic conv_pair(int c0, logic [15:0] r0, int c1, logic [15:0] r1);
        chan = c0[1:0]; raw = r0; conv_valid = 1'b1;
        @(negedge clk);
        model_conv(c0, r0);
        chk("pair first R8", {31'h0, done}, 32'h1);
        check_all("pair first");
        chan = c1[1:0]; raw = r1;
        @(negedge clk);
        conv_valid = 1'b0;
        model_conv(c1, r1);
        chk("pair second R8", {31'h0, done}, 32'h1);
        check_all("pair second");
        @(negedge clk);
        chk("pair end R8", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < NCH; i++) begin
            exp_res[i] = '0; exp_hi[i] = 1'b0; exp_lo[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done in reset", {31'h0, done}, 32'h0);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R3: zero shift passes raw; R2 channel 0 field bits 2..0
        shift_cfg = 16'h0000;
        conv(0, 16'hBEEF, "R3 shift0");
        // R3: count 7 on all-ones gives 01FF; R2 channel 1 field bits 6..4
        shift_cfg = 16'h0070;
        conv(1, 16'hFFFF, "R3 shift7 ch1");
        chk("R3 shift7 value", {16'h0, result[31:16]}, 32'h0000_01FF);
        // R2: byte 1 fields for channels 2 and 3
        shift_cfg = 16'h5300;
        conv(2, 16'h8000, "R2 ch2 shift3");
        chk("R2 ch2 value", {16'h0, result[47:32]}, 32'h0000_1000);
        conv(3, 16'h8000, "R2 ch3 shift5");
        chk("R2 ch3 value", {16'h0, result[63:48]}, 32'h0000_0400);

        // R9: spare bits 3 and 7 ignored
        shift_cfg = 16'h8888;
        conv(0, 16'h1234, "R9 spare bits");
        chk("R9 value", {16'h0, result[15:0]}, 32'h0000_1234);

        // R5/R6: equality leaves flags clear; one above/below sets them
        shift_cfg = 16'h0001;
        thr_hi[15:0] = 16'h0100; thr_lo[15:0] = 16'h0100;
        conv(0, 16'h0200, "R5 R6 equal");
        chk("R5 equal clear", {31'h0, alarm_hi[0]}, 32'h0);
        chk("R6 equal clear", {31'h0, alarm_lo[0]}, 32'h0);
        conv(0, 16'h0202, "R5 above");
        chk("R5 above set", {31'h0, alarm_hi[0]}, 32'h1);
        conv(0, 16'h01FE, "R6 below");
        chk("R6 below set", {31'h0, alarm_lo[0]}, 32'h1);

        // R7: idle cycles hold everything
        repeat (5) @(negedge clk);
        check_all("R7 idle");

        // R8: back-to-back conversions
        conv_pair(2, 16'h4321, 3, 16'hFEDC);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            shift_cfg = $urandom;
            thr_hi    = {$urandom, $urandom};
            thr_lo    = {$urandom, $urandom};
            if (n % 5 == 0) conv_pair($urandom_range(3), $urandom, $urandom_range(3), $urandom);
            else            conv($urandom_range(3), $urandom, "random R3");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule